// File: doc/BRIEF.md
# Eight-Stage Load and Branch Interlock

This block is the hazard and control unit for an in-order integer pipeline of eight stages: two fetch stages (IF, IS), a decode and register-read stage (RF), execute (EX), two data-cache stages (DF, DS), a tag-check stage (TC) and write-back (WB). Hazard detection happens while an instruction sits in RF. ALU results are forwarded to EX, so only loads can make a younger instruction wait. Load data becomes usable only once the load has left DS. An instruction that reads a load's destination right after the load therefore waits two cycles. One that reads it two instructions later waits one cycle.

Branches resolve in EX. The instruction behind a branch is its delay slot and normally executes. When the branch is taken, the two younger instructions in IF and IS are squashed and the fetch address is redirected to the target. A "likely" branch that is not taken annuls its delay slot, which is then in RF. The unit keeps a small shadow of the instructions that have left RF, so it knows which loads and branches are in flight. From that shadow it drives the stall, bubble and flush strobes and the redirect.

Top module: `loadBranchInterlock`

## Requirements
- R1: After reset, no load is in flight, so an RF instruction that reads any register raises no stall, and no flush or redirect is driven.
- R2: An instruction in RF that reads (through either source whose use flag is 1) the nonzero destination of a load one instruction ahead stalls for exactly two cycles.
- R3: An instruction in RF that reads the destination of a load two instructions ahead stalls for exactly one cycle.
- R4: Register 0, and a source whose use flag is 0, never cause a stall.
- R5: A non-load instruction never causes a stall for a dependent instruction behind it.
- R6: While stalled, bubbleEx is 1, and the held RF instruction proceeds in the cycle after the last stall cycle.
- R7: A taken branch in EX drives pcRedirect, flushIf and flushIs high for that single cycle, with pcTarget equal to exTarget. flushRf stays 0, so the delay slot executes.
- R8: A likely branch that is not taken drives flushRf and bubbleEx high and no redirect. The annulled delay slot neither stalls nor, if it is a load, makes any later instruction stall.
- R9: An ordinary branch that is not taken drives no strobe. A likely branch that is taken redirects without annulling its delay slot.
- R10: exTaken is ignored unless a branch occupies EX. A branch still in RF never redirects.
- R11: When a taken branch in EX coincides with a load stall of its delay slot, stall and redirect are both driven in that cycle. The stall ends once the load data is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rfValid | input | 1 | RF holds an instruction |
| rfIsLoad | input | 1 | RF instruction is a load |
| rfIsBranch | input | 1 | RF instruction is a branch |
| rfIsLikely | input | 1 | RF branch is of the likely kind |
| rfDest | input | REG_W | RF instruction destination register |
| rfSrcA | input | REG_W | First source register |
| rfUseA | input | 1 | First source is read |
| rfSrcB | input | REG_W | Second source register |
| rfUseB | input | 1 | Second source is read |
| exTaken | input | 1 | Outcome of the branch in EX (1 = taken) |
| exTarget | input | PC_W | Target address of the branch in EX |
| stall | output | 1 | Hold PC, IF, IS and RF |
| bubbleEx | output | 1 | Place a no-op into EX on the next edge |
| flushIf | output | 1 | Squash the IF instruction |
| flushIs | output | 1 | Squash the IS instruction |
| flushRf | output | 1 | Annul the RF instruction |
| pcRedirect | output | 1 | Load the fetch PC from pcTarget |
| pcTarget | output | PC_W | Redirect address |

## Verification
The checker assumes that the RF inputs stay the same for as long as stall is high. It also assumes that the instruction right behind a branch (its delay slot) is present in RF when the branch reaches EX, and that a delay slot is never itself a branch. Under those conditions a stall can never outlast the load latency, and a redirect never lasts two cycles in a row. The directed tasks keep within these rules. They re-present the held instruction on every stall cycle, place an instruction after each branch, and only drive exTaken high in the cycle where the branch has reached EX, except in the scenario that tests that it is ignored.

// File: rtl/hazPkg.sv
package hazPkg;

  // Strobes from the decision logic to the shadow pipeline and out of the block.
  typedef struct packed {
    logic stall;
    logic bubbleEx;
    logic flushIf;
    logic flushIs;
    logic flushRf;
    logic redirect;
  } ctlStrobes_t;

endpackage

// File: rtl/hazShadow.sv
module hazShadow
  import hazPkg::*;
#(
  parameter int REG_W    = 5,
  parameter int LOAD_LAT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rfValid,
  input  logic             rfIsLoad,
  input  logic             rfIsBranch,
  input  logic             rfIsLikely,
  input  logic [REG_W-1:0] rfDest,
  input  logic [REG_W-1:0] rfSrcA,
  input  logic             rfUseA,
  input  logic [REG_W-1:0] rfSrcB,
  input  logic             rfUseB,
  input  ctlStrobes_t      strobes,
  output logic             hazard,
  output logic             exBranch,
  output logic             exLikely
);

  // Index 0 is EX, index k is k stages past EX. Only the stages whose load
  // data is not yet usable are tracked.
  localparam int DEPTH = LOAD_LAT;

  logic [DEPTH-1:0] shValid;
  logic [DEPTH-1:0] shLoad;
  logic [REG_W-1:0] shDest [DEPTH];
  logic             brQ;
  logic             lkQ;
  logic             enterEx;
  logic [DEPTH-1:0] stageHit;

  assign enterEx = rfValid && !strobes.bubbleEx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shValid <= '0;
      shLoad  <= '0;
      brQ     <= 1'b0;
      lkQ     <= 1'b0;
      for (int k = 0; k < DEPTH; k++) shDest[k] <= '0;
    end else begin
      shValid[0] <= enterEx;
      shLoad[0]  <= enterEx && rfIsLoad;
      shDest[0]  <= rfDest;
      brQ        <= enterEx && rfIsBranch;
      lkQ        <= enterEx && rfIsBranch && rfIsLikely;
      for (int k = 1; k < DEPTH; k++) begin
        shValid[k] <= shValid[k-1];
        shLoad[k]  <= shLoad[k-1];
        shDest[k]  <= shDest[k-1];
      end
    end
  end

  // One comparator pair per load-shadow stage.
  for (genvar g = 0; g < DEPTH; g++) begin : gHit
    logic destLive;
    logic matchA;
    logic matchB;
    assign destLive    = shValid[g] && shLoad[g] && (shDest[g] != '0);
    assign matchA      = rfUseA && (rfSrcA == shDest[g]);
    assign matchB      = rfUseB && (rfSrcB == shDest[g]);
    assign stageHit[g] = destLive && (matchA || matchB);
  end

  assign hazard   = rfValid && (|stageHit);
  assign exBranch = brQ;
  assign exLikely = lkQ;

endmodule

// File: rtl/hazCtl.sv
module hazCtl
  import hazPkg::*;
(
  input  logic        hazard,
  input  logic        exBranch,
  input  logic        exLikely,
  input  logic        exTaken,
  output ctlStrobes_t strobes
);

  logic takenNow;
  logic annulNow;

  assign takenNow = exBranch && exTaken;
  assign annulNow = exBranch && exLikely && !exTaken;

  always_comb begin
    strobes          = '0;
    // An annulled delay slot never waits on a load.
    strobes.stall    = hazard && !annulNow;
    strobes.flushRf  = annulNow;
    strobes.bubbleEx = strobes.stall || annulNow;
    // Wrong-path fetches go regardless of any stall in RF.
    strobes.flushIf  = takenNow;
    strobes.flushIs  = takenNow;
    strobes.redirect = takenNow;
  end

endmodule

// File: rtl/loadBranchInterlock.sv
module loadBranchInterlock
  import hazPkg::*;
#(
  parameter int REG_W    = 5,
  parameter int PC_W     = 32,
  parameter int LOAD_LAT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rfValid,
  input  logic             rfIsLoad,
  input  logic             rfIsBranch,
  input  logic             rfIsLikely,
  input  logic [REG_W-1:0] rfDest,
  input  logic [REG_W-1:0] rfSrcA,
  input  logic             rfUseA,
  input  logic [REG_W-1:0] rfSrcB,
  input  logic             rfUseB,
  input  logic             exTaken,
  input  logic [PC_W-1:0]  exTarget,
  output logic             stall,
  output logic             bubbleEx,
  output logic             flushIf,
  output logic             flushIs,
  output logic             flushRf,
  output logic             pcRedirect,
  output logic [PC_W-1:0]  pcTarget
);

  ctlStrobes_t strobes;
  logic        hazard;
  logic        exBranch;
  logic        exLikely;

  hazShadow #(.REG_W(REG_W), .LOAD_LAT(LOAD_LAT)) u_shadow (
    .clk       (clk),
    .rstN      (rstN),
    .rfValid   (rfValid),
    .rfIsLoad  (rfIsLoad),
    .rfIsBranch(rfIsBranch),
    .rfIsLikely(rfIsLikely),
    .rfDest    (rfDest),
    .rfSrcA    (rfSrcA),
    .rfUseA    (rfUseA),
    .rfSrcB    (rfSrcB),
    .rfUseB    (rfUseB),
    .strobes   (strobes),
    .hazard    (hazard),
    .exBranch  (exBranch),
    .exLikely  (exLikely)
  );

  hazCtl u_ctl (
    .hazard  (hazard),
    .exBranch(exBranch),
    .exLikely(exLikely),
    .exTaken (exTaken),
    .strobes (strobes)
  );

  assign stall      = strobes.stall;
  assign bubbleEx   = strobes.bubbleEx;
  assign flushIf    = strobes.flushIf;
  assign flushIs    = strobes.flushIs;
  assign flushRf    = strobes.flushRf;
  assign pcRedirect = strobes.redirect;
  assign pcTarget   = exTarget;

endmodule

// File: rtl/loadBranchInterlockChk.sv
module loadBranchInterlockChk #(
  parameter int REG_W    = 5,
  parameter int LOAD_LAT = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             rfValid,
  input logic [REG_W-1:0] rfSrcA,
  input logic             rfUseA,
  input logic [REG_W-1:0] rfSrcB,
  input logic             rfUseB,
  input logic             exTaken,
  input logic             stall,
  input logic             bubbleEx,
  input logic             flushIf,
  input logic             flushIs,
  input logic             flushRf,
  input logic             pcRedirect
);

  // Number of consecutive stall cycles before the current one.
  int stallRun;

  always_ff @(posedge clk) begin
    if (!rstN)      stallRun <= 0;
    else if (stall) stallRun <= stallRun + 1;
    else            stallRun <= 0;
  end

  a_r2_stall_bubbles: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> bubbleEx);

  a_r3_stall_bounded: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (stallRun < LOAD_LAT));

  a_r4_stall_real_source: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (rfValid && ((rfUseA && rfSrcA != '0) || (rfUseB && rfSrcB != '0))));

  a_r7_redirect_flushes: assert property (@(posedge clk) disable iff (!rstN)
    pcRedirect |-> (flushIf && flushIs && !flushRf && exTaken));

  a_r7_redirect_single: assert property (@(posedge clk) disable iff (!rstN)
    pcRedirect |=> !pcRedirect);

  a_r8_annul_alone: assert property (@(posedge clk) disable iff (!rstN)
    flushRf |-> (bubbleEx && !stall && !pcRedirect && !exTaken));

  a_r10_fetch_flush_needs_redirect: assert property (@(posedge clk) disable iff (!rstN)
    (flushIf || flushIs) |-> pcRedirect);

endmodule

bind loadBranchInterlock loadBranchInterlockChk #(.REG_W(REG_W), .LOAD_LAT(LOAD_LAT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rfValid   (rfValid),
  .rfSrcA    (rfSrcA),
  .rfUseA    (rfUseA),
  .rfSrcB    (rfSrcB),
  .rfUseB    (rfUseB),
  .exTaken   (exTaken),
  .stall     (stall),
  .bubbleEx  (bubbleEx),
  .flushIf   (flushIf),
  .flushIs   (flushIs),
  .flushRf   (flushRf),
  .pcRedirect(pcRedirect)
);

// File: tb/test_loadBranchInterlock.sv
module test_loadBranchInterlock;

  localparam int CLK_PERIOD = 10;
  localparam int REG_W      = 5;
  localparam int PC_W       = 32;
  localparam int WATCH      = 5000;
  localparam logic [PC_W-1:0] TGT = 32'h0000_4A00;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             rfValid = 1'b0, rfIsLoad = 1'b0, rfIsBranch = 1'b0, rfIsLikely = 1'b0;
  logic [REG_W-1:0] rfDest = '0, rfSrcA = '0, rfSrcB = '0;
  logic             rfUseA = 1'b0, rfUseB = 1'b0;
  logic             exTaken = 1'b0;
  logic [PC_W-1:0]  exTarget = TGT;
  logic             stall, bubbleEx, flushIf, flushIs, flushRf, pcRedirect;
  logic [PC_W-1:0]  pcTarget;

  int  nChk  = 0;
  int  nFail = 0;
  bit  done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loadBranchInterlock #(.REG_W(REG_W), .PC_W(PC_W), .LOAD_LAT(2)) i_loadBranchInterlock (
    .clk(clk), .rstN(rstN),
    .rfValid(rfValid), .rfIsLoad(rfIsLoad), .rfIsBranch(rfIsBranch), .rfIsLikely(rfIsLikely),
    .rfDest(rfDest), .rfSrcA(rfSrcA), .rfUseA(rfUseA), .rfSrcB(rfSrcB), .rfUseB(rfUseB),
    .exTaken(exTaken), .exTarget(exTarget),
    .stall(stall), .bubbleEx(bubbleEx), .flushIf(flushIf), .flushIs(flushIs),
    .flushRf(flushRf), .pcRedirect(pcRedirect), .pcTarget(pcTarget)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected strobes: stall, bubbleEx, flushIf, flushIs, flushRf, pcRedirect.
  task automatic expect6(input string req, input bit st, bub, fi, fs, fr, rd);
    check(req, "stall",      stall,      st);
    check(req, "bubbleEx",   bubbleEx,   bub);
    check(req, "flushIf",    flushIf,    fi);
    check(req, "flushIs",    flushIs,    fs);
    check(req, "flushRf",    flushRf,    fr);
    check(req, "pcRedirect", pcRedirect, rd);
  endtask

  // Present one RF instruction after a falling edge and sample 1 time unit later.
  task automatic put(input bit v, ld, br, lk, input int dest, input int sa, input bit ua,
                     input int sb, input bit ub, input bit tk);
    @(negedge clk);
    rfValid = v; rfIsLoad = ld; rfIsBranch = br; rfIsLikely = lk;
    rfDest = REG_W'(dest); rfSrcA = REG_W'(sa); rfUseA = ua;
    rfSrcB = REG_W'(sb); rfUseB = ub; exTaken = tk;
    #1;
  endtask

  task automatic idle();
    for (int i = 0; i < 3; i++) put(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic tReset();
    put(1, 0, 0, 0, 3, 5, 1, 6, 1, 1);
    expect6("R1", 0, 0, 0, 0, 0, 0);
    idle();
  endtask

  task automatic tLoadAdjacent();
    put(1, 1, 0, 0, 5, 1, 1, 0, 0, 0);           // load r5
    expect6("R2", 0, 0, 0, 0, 0, 0);
    put(1, 0, 0, 0, 2, 5, 1, 0, 0, 0);           // reads r5, load in EX
    expect6("R2", 1, 1, 0, 0, 0, 0);
    put(1, 0, 0, 0, 2, 5, 1, 0, 0, 0);           // held, load in DF
    expect6("R6", 1, 1, 0, 0, 0, 0);
    put(1, 0, 0, 0, 2, 5, 1, 0, 0, 0);           // load in DS: proceeds
    expect6("R6", 0, 0, 0, 0, 0, 0);
    idle();
    put(1, 1, 0, 0, 8, 0, 0, 0, 0, 0);           // load r8, consumer via source B
    put(1, 0, 0, 0, 2, 1, 1, 8, 1, 0);
    check("R2", "stall srcB first", stall, 1);
    put(1, 0, 0, 0, 2, 1, 1, 8, 1, 0);
    check("R2", "stall srcB second", stall, 1);
    put(1, 0, 0, 0, 2, 1, 1, 8, 1, 0);
    check("R2", "stall srcB released", stall, 0);
    idle();
  endtask

  task automatic tLoadDistTwo();
    put(1, 1, 0, 0, 6, 0, 0, 0, 0, 0);           // load r6
    put(1, 0, 0, 0, 4, 1, 1, 2, 1, 0);           // independent
    check("R3", "independent stall", stall, 0);
    put(1, 0, 0, 0, 4, 6, 1, 0, 0, 0);           // reads r6, load in DF
    expect6("R3", 1, 1, 0, 0, 0, 0);
    put(1, 0, 0, 0, 4, 6, 1, 0, 0, 0);
    expect6("R3", 0, 0, 0, 0, 0, 0);
    idle();
  endtask

  task automatic tNoDependence();
    put(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);           // load into r0
    put(1, 0, 0, 0, 2, 0, 1, 0, 1, 0);
    check("R4", "r0 stall", stall, 0);
    idle();
    put(1, 1, 0, 0, 7, 0, 0, 0, 0, 0);           // load r7
    put(1, 0, 0, 0, 2, 7, 0, 3, 1, 0);           // r7 named but unused
    check("R4", "unused source stall", stall, 0);
    idle();
    put(1, 0, 0, 0, 9, 1, 1, 0, 0, 0);           // ALU writes r9
    put(1, 0, 0, 0, 2, 9, 1, 9, 1, 0);
    check("R5", "alu producer stall", stall, 0);
    put(1, 0, 0, 0, 2, 9, 1, 0, 0, 0);
    check("R5", "alu producer stall dist2", stall, 0);
    idle();
  endtask

  task automatic tTakenBranch();
    put(1, 0, 1, 0, 0, 1, 1, 0, 0, 0);           // branch in RF
    check("R10", "redirect from RF", pcRedirect, 0);
    put(1, 0, 0, 0, 3, 1, 1, 0, 0, 1);           // delay slot; branch in EX taken
    expect6("R7", 0, 0, 1, 1, 0, 1);
    check("R7", "pcTarget", pcTarget, TGT);
    put(1, 0, 0, 0, 3, 2, 1, 0, 0, 0);
    expect6("R7", 0, 0, 0, 0, 0, 0);
    idle();
  endtask

  task automatic tLikelyNotTaken();
    put(1, 1, 0, 0, 11, 0, 0, 0, 0, 0);          // load r11
    put(1, 0, 1, 1, 0, 0, 0, 0, 0, 0);           // likely branch
    check("R8", "branch stall", stall, 0);
    put(1, 1, 0, 0, 10, 11, 1, 0, 0, 0);         // delay slot: load r10 reading r11
    expect6("R8", 0, 1, 0, 0, 1, 0);
    put(1, 0, 0, 0, 2, 10, 1, 0, 0, 0);          // reads annulled load's r10
    expect6("R8", 0, 0, 0, 0, 0, 0);
    put(1, 0, 0, 0, 2, 10, 1, 0, 0, 0);
    check("R8", "annulled load dist2 stall", stall, 0);
    idle();
  endtask

  task automatic tOtherBranches();
    put(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);           // ordinary branch
    put(1, 0, 0, 0, 3, 1, 1, 0, 0, 0);           // not taken
    expect6("R9", 0, 0, 0, 0, 0, 0);
    idle();
    put(1, 0, 1, 1, 0, 0, 0, 0, 0, 0);           // likely branch
    put(1, 0, 0, 0, 3, 1, 1, 0, 0, 1);           // taken
    expect6("R9", 0, 0, 1, 1, 0, 1);
    idle();
    put(1, 0, 0, 0, 3, 1, 1, 0, 0, 1);           // taken flag with no branch in EX
    expect6("R10", 0, 0, 0, 0, 0, 0);
    put(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    expect6("R10", 0, 0, 0, 0, 0, 0);
    idle();
  endtask

  task automatic tRedirectWithStall();
    put(1, 1, 0, 0, 12, 0, 0, 0, 0, 0);          // load r12
    put(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);           // branch
    put(1, 0, 0, 0, 3, 12, 1, 0, 0, 1);          // delay slot reads r12, branch taken
    expect6("R11", 1, 1, 1, 1, 0, 1);
    put(1, 0, 0, 0, 3, 12, 1, 0, 0, 0);          // held delay slot, load in DS
    expect6("R11", 0, 0, 0, 0, 0, 0);
    idle();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tReset();
    tLoadAdjacent();
    tLoadDistTwo();
    tNoDependence();
    tTakenBranch();
    tLikelyNotTaken();
    tOtherBranches();
    tRedirectWithStall();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (WATCH) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCH);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

endmodule